// File: doc/BRIEF.md
# Control-Transfer Record and Debug-Trap Controller

This block sits beside a simple processor core and watches the control transfers the core retires: taken branches, serviced interrupts and raised exceptions. Each retired transfer that is recorded goes into a small circular stack as a source address, a destination address and a kind code. The newest entry replaces the oldest, so debug software can read the latest history and trace a fault back toward its origin. The stack is read through an indexed port that has no side effects, and a pointer shows which slot holds the newest entry.

A three-bit control register governs the block. The bits are record enable, message enable and transfer-step enable. A trap-flag level comes in from the core. When message enable is set, every recorded transfer also leaves the block as a message on a valid/ready stream. A two-entry buffer absorbs stalls, and a sticky flag marks any message that was lost. When transfer stepping is armed, the block requests a debug exception on the next control transfer instead of after every instruction. It also applies the flag side effects of that exception: record enable and step enable are cleared, the core is told to clear its trap flag, and the stored records stay as they were.

Top module: `cft_monitor`

## Requirements
- R1: After reset the control register reads 0, the newest-entry pointer reads 3, every stack entry reads zero, and dbg_req, tf_clr, msg_valid and ovf are low.
- R2: While record enable (control bit 0) or message enable (control bit 1) is set, a single transfer is written to slot pointer+1 and the pointer advances by one, wrapping modulo 4, so the fifth record overwrites the oldest. An entry's kind reads 00 for a branch, 01 for an interrupt and 10 for an exception.
- R3: A branch and an interrupt or exception retired in the same cycle are both recorded. The branch goes to pointer+1, the other transfer goes to pointer+2, and the pointer advances by two.
- R4: With control bits 0 and 1 both clear, transfers leave the pointer and every stack entry unchanged.
- R5: With step enable (control bit 2) set and tf_in high, a cycle that carries any transfer makes dbg_req and tf_clr high for exactly the following cycle. Without both conditions, and with ext_dbg low, no request is raised.
- R6: A debug exception clears control bits 0 and 2 in the cycle after the triggering transfer and leaves bit 1 unchanged. tf_clr is raised with it only when bit 2 was set.
- R7: A debug exception leaves the earlier stack entries intact, and the transfer that triggered it is still recorded.
- R8: A pulse on ext_dbg raises dbg_req in the next cycle and clears record enable.
- R9: With message enable set, each recorded transfer produces exactly one message, in retirement order (branch before interrupt/exception in a shared cycle). The layout is msg_data[65:34] source, [33:2] destination, [1:0] kind.
- R10: A stalled message holds msg_valid and msg_data steady. Up to two messages are buffered, and a message that finds the buffer full is dropped and sets ovf, which then stays set until reset.
- R11: A control write takes effect in the next cycle, and its value wins over the automatic clears of a debug exception in the same cycle.
- R12: With record enable clear and message enable set, transfers are still recorded into the stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write value: bit0 record, bit1 message, bit2 step |
| cfg_rdata | output | 3 | Current control register |
| tf_in | input | 1 | Trap flag level from the core |
| ext_dbg | input | 1 | Debug exception raised by other debug logic |
| br_valid | input | 1 | A taken branch retires this cycle |
| br_src | input | 32 | Branch source address |
| br_dst | input | 32 | Branch destination address |
| ie_valid | input | 1 | An interrupt or exception is taken this cycle |
| ie_is_exc | input | 1 | 1 = exception, 0 = interrupt |
| ie_src | input | 32 | Interrupted/faulting address |
| ie_dst | input | 32 | Handler address |
| dbg_req | output | 1 | Debug exception request pulse |
| tf_clr | output | 1 | Pulse telling the core to clear its trap flag |
| tos | output | 2 | Slot index of the newest record |
| rd_idx | input | 2 | Stack read index |
| rd_src | output | 32 | Source address of the indexed entry |
| rd_dst | output | 32 | Destination address of the indexed entry |
| rd_kind | output | 2 | Kind of the indexed entry |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_data | output | 66 | Message: source, destination, kind |
| ovf | output | 1 | Sticky message-loss flag |

## Verification
A corrupted pointer shows up on the tos port in the cycle after the transfer. It also shows one read later, when the indexed port returns an entry from the wrong slot. A wrong write order for a shared-cycle pair, or a wrong lane in the message buffer, appears at the stream output as messages out of order or with fields swapped, as soon as the consumer accepts them. A wrong flag clear is visible on cfg_rdata and tf_clr one cycle after the triggering transfer.

// File: rtl/cft_pkg.sv
package cft_pkg;
  typedef enum logic [1:0] {
    XK_BRANCH = 2'b00,
    XK_INTR   = 2'b01,
    XK_EXC    = 2'b10
  } xfer_kind_e;

  localparam int CFG_W    = 3;
  localparam int CFG_REC  = 0;
  localparam int CFG_MSG  = 1;
  localparam int CFG_STEP = 2;
endpackage

// File: rtl/cft_cfg_reg.sv
module cft_cfg_reg
  import cft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             dbg_fire,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;

  // software write outranks the exception side effects
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = wr_data;
    end else if (dbg_fire) begin
      cfg_d[CFG_REC]  = 1'b0;
      cfg_d[CFG_STEP] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cft_trap_unit.sv
module cft_trap_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic tf_in,
  input  logic xfer_any,
  input  logic ext_dbg,
  output logic dbg_fire,
  output logic dbg_req_q,
  output logic tf_clr_q
);
  logic dbg_req_d, tf_clr_d;

  always_comb begin
    dbg_fire  = (step_en & tf_in & xfer_any) | ext_dbg;
    dbg_req_d = dbg_fire;
    tf_clr_d  = dbg_fire & step_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_req_q <= 1'b0;
      tf_clr_q  <= 1'b0;
    end else begin
      dbg_req_q <= dbg_req_d;
      tf_clr_q  <= tf_clr_d;
    end
  end
endmodule

// File: rtl/cft_ring.sv
// Circular record store; DEPTH must be a power of two.
module cft_ring #(
  parameter int DEPTH = 4,
  parameter int REC_W = 66,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  logic [REC_W-1:0] rec_a,
  input  logic             push_b,
  input  logic [REC_W-1:0] rec_b,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [PTR_W-1:0] tos_q,
  output logic [REC_W-1:0] rd_rec
);
  logic [PTR_W-1:0] tos_d, slot_a, slot_b;
  logic [REC_W-1:0] ent_q [DEPTH];

  always_comb begin
    slot_a = tos_q + PTR_W'(1);
    slot_b = push_a ? tos_q + PTR_W'(2) : tos_q + PTR_W'(1);
    tos_d  = tos_q + PTR_W'(push_a) + PTR_W'(push_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tos_q <= PTR_W'(DEPTH - 1);
    else        tos_q <= tos_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             hit_a, hit_b, ent_en;
    logic [REC_W-1:0] ent_d;
    always_comb begin
      hit_a  = push_a && (slot_a == PTR_W'(i));
      hit_b  = push_b && (slot_b == PTR_W'(i));
      ent_en = hit_a | hit_b;
      ent_d  = hit_b ? rec_b : rec_a;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= '0;
      else if (ent_en) ent_q[i] <= ent_d;
    end
  end

  assign rd_rec = ent_q[rd_idx];
endmodule

// File: rtl/cft_msg_buf.sv
// Small message queue taking up to two pushes per cycle; DEPTH a power of two, >= 2.
module cft_msg_buf #(
  parameter int W     = 66,
  parameter int DEPTH = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] data_a,
  input  logic         push_b,
  input  logic [W-1:0] data_b,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         ovf
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d, slot_a, slot_b;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   room, need_b;
  logic             pop, acc_a, acc_b, drop, ovf_q, ovf_d;

  always_comb begin
    pop    = (cnt_q != '0) && out_ready;
    room   = (CNT_W+1)'(DEPTH) - {1'b0, cnt_q} + (CNT_W+1)'(pop);
    acc_a  = push_a && (room >= (CNT_W+1)'(1));
    need_b = acc_a ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
    acc_b  = push_b && (room >= need_b);
    drop   = (push_a && !acc_a) || (push_b && !acc_b);
    slot_a = wr_q;
    slot_b = wr_q + PTR_W'(acc_a);
    wr_d   = wr_q + PTR_W'(acc_a) + PTR_W'(acc_b);
    rd_d   = rd_q + PTR_W'(pop);
    cnt_d  = cnt_q + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(pop);
    ovf_d  = ovf_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic         hit_a, hit_b, slot_en;
    logic [W-1:0] slot_d;
    always_comb begin
      hit_a   = acc_a && (slot_a == PTR_W'(i));
      hit_b   = acc_b && (slot_b == PTR_W'(i));
      slot_en = hit_a | hit_b;
      slot_d  = hit_b ? data_b : data_a;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_en) mem_q[i] <= slot_d;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign ovf       = ovf_q;
endmodule

// File: rtl/cft_monitor.sv
module cft_monitor
  import cft_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REC_DEP  = 4,
  parameter int MSG_DEP  = 2,
  localparam int PTR_W   = $clog2(REC_DEP),
  localparam int REC_W   = 2 * ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              tf_in,
  input  logic              ext_dbg,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_src,
  input  logic [ADDR_W-1:0] br_dst,
  input  logic              ie_valid,
  input  logic              ie_is_exc,
  input  logic [ADDR_W-1:0] ie_src,
  input  logic [ADDR_W-1:0] ie_dst,
  output logic              dbg_req,
  output logic              tf_clr,
  output logic [PTR_W-1:0]  tos,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [1:0]        rd_kind,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [REC_W-1:0]  msg_data,
  output logic              ovf
);
  logic [CFG_W-1:0] cfg_q;
  logic             dbg_fire, rec_on, push_a, push_b, msg_a, msg_b;
  xfer_kind_e       kind_b;
  logic [REC_W-1:0] rec_a, rec_b, rd_rec;

  always_comb begin
    rec_on = cfg_q[CFG_REC] | cfg_q[CFG_MSG];
    push_a = br_valid & rec_on;
    push_b = ie_valid & rec_on;
    msg_a  = push_a & cfg_q[CFG_MSG];
    msg_b  = push_b & cfg_q[CFG_MSG];
    kind_b = ie_is_exc ? XK_EXC : XK_INTR;
    rec_a  = {br_src, br_dst, XK_BRANCH};
    rec_b  = {ie_src, ie_dst, kind_b};
  end

  cft_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .dbg_fire (dbg_fire),
    .cfg_q    (cfg_q)
  );

  cft_trap_unit u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (cfg_q[CFG_STEP]),
    .tf_in     (tf_in),
    .xfer_any  (br_valid | ie_valid),
    .ext_dbg   (ext_dbg),
    .dbg_fire  (dbg_fire),
    .dbg_req_q (dbg_req),
    .tf_clr_q  (tf_clr)
  );

  cft_ring #(.DEPTH(REC_DEP), .REC_W(REC_W)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_a (push_a),
    .rec_a  (rec_a),
    .push_b (push_b),
    .rec_b  (rec_b),
    .rd_idx (rd_idx),
    .tos_q  (tos),
    .rd_rec (rd_rec)
  );

  cft_msg_buf #(.W(REC_W), .DEPTH(MSG_DEP)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_a    (msg_a),
    .data_a    (rec_a),
    .push_b    (msg_b),
    .data_b    (rec_b),
    .out_ready (msg_ready),
    .out_valid (msg_valid),
    .out_data  (msg_data),
    .ovf       (ovf)
  );

  assign cfg_rdata = cfg_q;
  assign rd_src    = rd_rec[REC_W-1 -: ADDR_W];
  assign rd_dst    = rd_rec[ADDR_W+1 : 2];
  assign rd_kind   = rd_rec[1:0];
endmodule

// File: rtl/cft_monitor_chk.sv
module cft_monitor_chk #(
  parameter int TOS_W = 2,
  parameter int MSG_W = 66
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [2:0]       cfg_wdata,
  input logic [2:0]       cfg_rdata,
  input logic             tf_in,
  input logic             ext_dbg,
  input logic             br_valid,
  input logic             ie_valid,
  input logic             dbg_req,
  input logic             tf_clr,
  input logic [TOS_W-1:0] tos,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [MSG_W-1:0] msg_data,
  input logic             ovf
);
  AST_STEP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[2] && tf_in && (br_valid || ie_valid) && !cfg_we)
      |=> (dbg_req && tf_clr && !cfg_rdata[0] && !cfg_rdata[2])); // R5
  AST_NO_SPURIOUS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_rdata[2] && tf_in && (br_valid || ie_valid)) && !ext_dbg) |=> !dbg_req); // R5
  AST_MSG_EN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[1] && !cfg_we) |=> cfg_rdata[1]); // R6
  AST_TFCLR_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tf_clr |-> dbg_req); // R6
  AST_EXT_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dbg && !cfg_we) |=> (dbg_req && !cfg_rdata[0])); // R8
  AST_CFG_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata))); // R11
  AST_TOS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(br_valid || ie_valid) || !(cfg_rdata[0] || cfg_rdata[1])) |=> $stable(tos)); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R10
endmodule

bind cft_monitor cft_monitor_chk #(.TOS_W(PTR_W), .MSG_W(REC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .tf_in     (tf_in),
  .ext_dbg   (ext_dbg),
  .br_valid  (br_valid),
  .ie_valid  (ie_valid),
  .dbg_req   (dbg_req),
  .tf_clr    (tf_clr),
  .tos       (tos),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_data  (msg_data),
  .ovf       (ovf)
);

// File: tb/sim_cft_monitor.sv
`timescale 1ns/1ps
module sim_cft_monitor;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, cfg_we, tf_in, ext_dbg;
  logic [2:0]  cfg_wdata, cfg_rdata;
  logic        br_valid, ie_valid, ie_is_exc;
  logic [31:0] br_src, br_dst, ie_src, ie_dst, rd_src, rd_dst;
  logic        dbg_req, tf_clr, msg_valid, msg_ready, ovf;
  logic [1:0]  tos, rd_idx, rd_kind;
  logic [65:0] msg_data;

  cft_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tf_in(tf_in), .ext_dbg(ext_dbg), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .ie_valid(ie_valid), .ie_is_exc(ie_is_exc), .ie_src(ie_src), .ie_dst(ie_dst),
    .dbg_req(dbg_req), .tf_clr(tf_clr), .tos(tos), .rd_idx(rd_idx), .rd_src(rd_src),
    .rd_dst(rd_dst), .rd_kind(rd_kind), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_data(msg_data), .ovf(ovf)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [65:0] exp_q[$];
  logic [2:0]  exp_cfg;
  logic [1:0]  exp_tos;
  logic [31:0] exp_src [4];
  logic [31:0] exp_dst [4];
  logic [1:0]  exp_kind [4];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted message (R9)
  always @(negedge clk) begin
    #1;
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected message", msg_data, '0);
      end else begin
        logic [65:0] e;
        e = exp_q.pop_front();
        chk(msg_data == e, "R9", "message", msg_data, e);
      end
    end
  end

  task automatic check_ring(input string req);
    chk(tos == exp_tos, req, "tos", 66'(tos), 66'(exp_tos));
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1;
      chk({rd_src, rd_dst, rd_kind} == {exp_src[i], exp_dst[i], exp_kind[i]}, req,
          $sformatf("entry %0d", i), {rd_src, rd_dst, rd_kind},
          {exp_src[i], exp_dst[i], exp_kind[i]});
    end
  endtask

  task automatic do_xfer(input bit bv, input logic [31:0] bs, input logic [31:0] bd,
                         input bit iv, input bit iexc, input logic [31:0] is_,
                         input logic [31:0] id, input int keep, input bit we,
                         input logic [2:0] wd, input string req);
    bit trap, rec;
    int nmsg;
    @(negedge clk);
    br_valid = bv; br_src = bs; br_dst = bd;
    ie_valid = iv; ie_is_exc = iexc; ie_src = is_; ie_dst = id;
    cfg_we = we; cfg_wdata = wd;
    trap = exp_cfg[2] && tf_in && (bv || iv);
    rec  = exp_cfg[0] || exp_cfg[1];
    nmsg = 0;
    if (rec && bv) begin
      exp_tos = exp_tos + 2'd1;
      exp_src[exp_tos] = bs; exp_dst[exp_tos] = bd; exp_kind[exp_tos] = 2'b00;
      if (exp_cfg[1] && nmsg < keep) exp_q.push_back({bs, bd, 2'b00});
      nmsg++;
    end
    if (rec && iv) begin
      exp_tos = exp_tos + 2'd1;
      exp_src[exp_tos] = is_; exp_dst[exp_tos] = id;
      exp_kind[exp_tos] = iexc ? 2'b10 : 2'b01;
      if (exp_cfg[1] && nmsg < keep) exp_q.push_back({is_, id, iexc ? 2'b10 : 2'b01});
      nmsg++;
    end
    if (we) exp_cfg = wd;
    else if (trap) begin exp_cfg[0] = 1'b0; exp_cfg[2] = 1'b0; end
    @(negedge clk);
    br_valid = 1'b0; ie_valid = 1'b0; cfg_we = 1'b0;
    chk(dbg_req == trap, req, "dbg_req", 66'(dbg_req), 66'(trap));
    chk(tf_clr == trap, req, "tf_clr", 66'(tf_clr), 66'(trap));
    chk(cfg_rdata == exp_cfg, req, "cfg", 66'(cfg_rdata), 66'(exp_cfg));
    if (trap) tf_in = 1'b0;
  endtask

  task automatic write_cfg(input logic [2:0] v, input string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_cfg = v;
    chk(cfg_rdata == v, req, "cfg write", 66'(cfg_rdata), 66'(v));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", '0, '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; tf_in = 1'b0; ext_dbg = 1'b0;
    br_valid = 1'b0; br_src = '0; br_dst = '0; ie_valid = 1'b0; ie_is_exc = 1'b0;
    ie_src = '0; ie_dst = '0; rd_idx = '0; msg_ready = 1'b1;
    exp_cfg = '0; exp_tos = 2'd3;
    for (int i = 0; i < 4; i++) begin exp_src[i] = '0; exp_dst[i] = '0; exp_kind[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cfg_rdata == 3'b000, "R1", "cfg", 66'(cfg_rdata), 66'(0));
    chk({dbg_req, tf_clr, msg_valid, ovf} == 4'b0, "R1", "flags",
        66'({dbg_req, tf_clr, msg_valid, ovf}), 66'(0));
    check_ring("R1");

    // R4 recording off
    do_xfer(1, 32'h1000, 32'h2000, 0, 0, 0, 0, 2, 0, 0, "R4");
    check_ring("R4");

    // R2 recording with wrap, mixed kinds
    write_cfg(3'b001, "R11");
    do_xfer(1, 32'h100, 32'h180, 0, 0, 0, 0, 2, 0, 0, "R2");
    do_xfer(0, 0, 0, 1, 0, 32'h200, 32'h8000, 2, 0, 0, "R2");
    do_xfer(0, 0, 0, 1, 1, 32'h300, 32'h9000, 2, 0, 0, "R2");
    do_xfer(1, 32'h400, 32'h480, 0, 0, 0, 0, 2, 0, 0, "R2");
    do_xfer(1, 32'h500, 32'h580, 0, 0, 0, 0, 2, 0, 0, "R2");
    check_ring("R2");

    // R3 branch and exception in one cycle
    do_xfer(1, 32'h600, 32'h680, 1, 1, 32'h680, 32'h9100, 2, 0, 0, "R3");
    check_ring("R3");

    // R9 messages, including a shared-cycle pair
    write_cfg(3'b011, "R11");
    do_xfer(1, 32'h700, 32'h780, 0, 0, 0, 0, 2, 0, 0, "R9");
    do_xfer(1, 32'h800, 32'h880, 1, 0, 32'h880, 32'h8800, 2, 0, 0, "R9");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending messages", 66'(exp_q.size()), 66'(0));

    // R12 record enable clear, message enable set
    write_cfg(3'b010, "R11");
    do_xfer(0, 0, 0, 1, 1, 32'h900, 32'h9900, 2, 0, 0, "R12");
    check_ring("R12");

    // R5 no trap when trap flag is low
    write_cfg(3'b101, "R11");
    do_xfer(1, 32'hA00, 32'hA80, 0, 0, 0, 0, 2, 0, 0, "R5");
    // R5 no trap on idle cycles with both armed
    tf_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(dbg_req == 1'b0, "R5", "idle no trap", 66'(dbg_req), 66'(0));
    // R5/R6/R7 trap on a transfer
    do_xfer(1, 32'hB00, 32'hB80, 0, 0, 0, 0, 2, 0, 0, "R6");
    check_ring("R7");
    @(negedge clk);
    chk(dbg_req == 1'b0, "R5", "single pulse", 66'(dbg_req), 66'(0));

    // R6 message enable survives a trap
    write_cfg(3'b111, "R11");
    tf_in = 1'b1;
    do_xfer(0, 0, 0, 1, 0, 32'hC00, 32'h8C00, 2, 0, 0, "R6");
    chk(cfg_rdata == 3'b010, "R6", "msg kept", 66'(cfg_rdata), 66'(3'b010));
    repeat (3) @(negedge clk);

    // R8 external debug request
    write_cfg(3'b001, "R11");
    @(negedge clk); ext_dbg = 1'b1;
    @(negedge clk); ext_dbg = 1'b0;
    chk(dbg_req == 1'b1, "R8", "dbg_req", 66'(dbg_req), 66'(1));
    chk(tf_clr == 1'b0, "R8", "tf_clr", 66'(tf_clr), 66'(0));
    chk(cfg_rdata == 3'b000, "R8", "cfg", 66'(cfg_rdata), 66'(0));
    exp_cfg = 3'b000;

    // R11 write wins over a same-cycle trap
    write_cfg(3'b101, "R11");
    tf_in = 1'b1;
    do_xfer(1, 32'hD00, 32'hD80, 0, 0, 0, 0, 2, 1, 3'b111, "R11");
    repeat (3) @(negedge clk);

    // R10 stall, buffering and overflow
    write_cfg(3'b010, "R11");
    msg_ready = 1'b0;
    do_xfer(1, 32'hE00, 32'hE80, 0, 0, 0, 0, 2, 0, 0, "R10");
    do_xfer(1, 32'hF00, 32'hF80, 0, 0, 0, 0, 2, 0, 0, "R10");
    chk(ovf == 1'b0, "R10", "ovf before full", 66'(ovf), 66'(0));
    do_xfer(0, 0, 0, 1, 1, 32'h1100, 32'h9900, 0, 0, 0, "R10");
    chk(ovf == 1'b1, "R10", "ovf set", 66'(ovf), 66'(1));
    chk(msg_valid && msg_data == exp_q[0], "R10", "held head", msg_data, exp_q[0]);
    @(negedge clk);
    msg_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "drained", 66'(exp_q.size()), 66'(0));
    chk(msg_valid == 1'b0, "R10", "empty", 66'(msg_valid), 66'(0));
    chk(ovf == 1'b1, "R10", "ovf sticky", 66'(ovf), 66'(1));
    check_ring("R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule